// File: doc/BRIEF.md
# H-bridge gate control logic

This block is the digital core of a full-bridge motor driver. It takes an enable, two direction inputs, an active-low request for an auxiliary gate output, and two undervoltage flags: one for the logic supply and one for the motor supply. It drives four gate enables, one for the high switch and one for the low switch of each half-bridge leg (A and B). It also drives the auxiliary gate output and an enable for the charge pump.

All inputs may be asynchronous. Each passes through a two-flop synchronizer. The undervoltage flags are then filtered, so that a flag counts only after it has held a new level for FILT_CYCLES clocks. The enable and the direction inputs select one of four actions: drive in one polarity, drive in the other polarity, brake with both low switches, or release the bridge. Each leg moves to its new switch state through an off interval of DEAD_CYCLES clocks, so the two switches of a leg never overlap. While either filtered flag is active, the bridge is released. The bridge follows the input pins again on its own once the fault clears.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With en_i high, dir_a_i high and dir_b_i low, the bridge settles with hs_a_o=1, ls_a_o=0, hs_b_o=0, ls_b_o=1. With dir_a_i low and dir_b_i high it settles with hs_a_o=0, ls_a_o=1, hs_b_o=1, ls_b_o=0.
- R2: With en_i high and both direction inputs high, both low switches are on and both high switches are off.
- R3: With en_i high and both direction inputs low, all four gate enables are 0.
- R4: With en_i low, both low switches are on and both high switches are off, whatever the direction inputs are.
- R5: pump_en_o equals en_i as it was sampled three clocks earlier.
- R6: Once either uv_logic_i or uv_motor_i has been high for FILT_CYCLES+3 consecutive clocks, all four gate enables are 0. A flag pulse shorter than FILT_CYCLES clocks has no effect on the gate enables.
- R7: When the undervoltage fault clears, the bridge returns to the state that the current en_i and direction inputs select. No other action is needed.
- R8: aux_gate_o is 1 when aux_req_n_i was low three clocks earlier, and 0 when it was high. The undervoltage flags do not affect it.
- R9: The high and low enables of a leg are never 1 together. A switch turns on only after both enables of its leg have been 0 for at least DEAD_CYCLES clocks.
- R10: While rst is high, all outputs are 0. A control change that needs no dead time reaches the outputs on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Bridge enable; low selects brake and charge-pump sleep |
| dir_a_i | input | 1 | Direction input A |
| dir_b_i | input | 1 | Direction input B |
| aux_req_n_i | input | 1 | Active-low request for the auxiliary gate |
| uv_logic_i | input | 1 | Logic-supply undervoltage flag |
| uv_motor_i | input | 1 | Motor-supply undervoltage flag |
| hs_a_o | output | 1 | High switch enable, leg A |
| ls_a_o | output | 1 | Low switch enable, leg A |
| hs_b_o | output | 1 | High switch enable, leg B |
| ls_b_o | output | 1 | Low switch enable, leg B |
| aux_gate_o | output | 1 | Auxiliary gate drive, active high |
| pump_en_o | output | 1 | Charge-pump enable |

## Verification
The bench samples leg A at the exact cycles of its dead window when the bridge reverses or leaves brake. A design that switched legs directly would show an early high-side turn-on or a shoot-through cycle. An undervoltage pulse one clock shorter than the filter length must leave the bridge driving in every cycle, which exposes a filter that is off by one or missing. A sustained fault must release the bridge exactly FILT_CYCLES+3 clocks after it begins. Once it clears, the bridge must resume in whatever polarity the pins select at that time, which catches a latched fault or a stale state. The auxiliary output is checked through a fault, and the enable-low brake is checked with the direction inputs set to the release pattern.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Switch state of one half-bridge leg
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_t;

  typedef struct packed {
    leg_t a;
    leg_t b;
  } leg_pair_t;

  // Maps the synchronized controls to a target state per leg.
  // A supply fault overrides everything; enable low brakes.
  function automatic leg_pair_t decode_drive(input logic fault,
                                             input logic en,
                                             input logic dir_a,
                                             input logic dir_b);
    leg_pair_t t;
    if (fault) begin
      t.a = LEG_OFF; t.b = LEG_OFF;
    end else if (!en) begin
      t.a = LEG_LO;  t.b = LEG_LO;
    end else begin
      unique case ({dir_a, dir_b})
        2'b10:   begin t.a = LEG_HI;  t.b = LEG_LO;  end
        2'b01:   begin t.a = LEG_LO;  t.b = LEG_HI;  end
        2'b11:   begin t.a = LEG_LO;  t.b = LEG_LO;  end
        default: begin t.a = LEG_OFF; t.b = LEG_OFF; end
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/hbg_glitch_filter.sv
module hbg_glitch_filter #(
  parameter int FILT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);

  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [CW-1:0] cnt;

  // clean_o takes a new level only after raw_i has differed for
  // FILT_CYCLES consecutive clocks; any return resets the count.
  always_ff @(posedge clk) begin
    if (rst) begin
      clean_o <= 1'b0;
      cnt     <= '0;
    end else if (raw_i != clean_o) begin
      if (cnt == CW'(FILT_CYCLES - 1)) begin
        clean_o <= raw_i;
        cnt     <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else begin
      cnt <= '0;
    end
  end

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  leg_t target_i,
  output logic hs_o,
  output logic ls_o
);

  localparam int CW = $clog2(DEAD_CYCLES + 1);

  leg_t          cur;
  logic [CW-1:0] dead_cnt;

  // Any move away from a conducting state passes through LEG_OFF.
  // A switch turns on only once dead_cnt has run down to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= LEG_OFF;
      dead_cnt <= CW'(DEAD_CYCLES);
    end else if (target_i != cur) begin
      if (cur != LEG_OFF) begin
        cur      <= LEG_OFF;
        dead_cnt <= CW'(DEAD_CYCLES - 1);
      end else if (dead_cnt == '0) begin
        cur <= target_i;
      end else begin
        dead_cnt <= dead_cnt - CW'(1);
      end
    end else if (dead_cnt != '0) begin
      dead_cnt <= dead_cnt - CW'(1);
    end
  end

  assign hs_o = (cur == LEG_HI);
  assign ls_o = (cur == LEG_LO);

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 16,
  parameter int FILT_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic dir_a_i,
  input  logic dir_b_i,
  input  logic aux_req_n_i,
  input  logic uv_logic_i,
  input  logic uv_motor_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o,
  output logic aux_gate_o,
  output logic pump_en_o
);

  localparam int NIN   = 6;
  localparam int NLEG  = 2;
  localparam int NFLAG = 2;
  // Bit order: 0 en, 1 dir_a, 2 dir_b, 3 aux_req_n, 4 uv_logic, 5 uv_motor
  localparam logic [NIN-1:0] SYNC_RST = 6'b00_1000;

  logic [NIN-1:0]   raw_in, syn_in;
  logic [NFLAG-1:0] flag_clean;
  logic             fault;
  leg_pair_t        tgt;
  leg_t             leg_tgt [NLEG];
  logic [NLEG-1:0]  hs, ls;

  assign raw_in = {uv_motor_i, uv_logic_i, aux_req_n_i, dir_b_i, dir_a_i, en_i};

  hbg_sync #(
    .W       (NIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn_in)
  );

  generate
    for (genvar f = 0; f < NFLAG; f++) begin : g_flt
      hbg_glitch_filter #(
        .FILT_CYCLES (FILT_CYCLES)
      ) u_flt (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (syn_in[4+f]),
        .clean_o (flag_clean[f])
      );
    end
  endgenerate

  assign fault = |flag_clean;

  always_comb begin
    tgt        = decode_drive(fault, syn_in[0], syn_in[1], syn_in[2]);
    leg_tgt[0] = tgt.a;
    leg_tgt[1] = tgt.b;
  end

  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      hbg_leg #(
        .DEAD_CYCLES (DEAD_CYCLES)
      ) u_leg (
        .clk      (clk),
        .rst      (rst),
        .target_i (leg_tgt[g]),
        .hs_o     (hs[g]),
        .ls_o     (ls[g])
      );
    end
  endgenerate

  assign hs_a_o = hs[0];
  assign ls_a_o = ls[0];
  assign hs_b_o = hs[1];
  assign ls_b_o = ls[1];

  // Charge pump sleeps with enable; the auxiliary gate is active-low requested
  // and independent of the supply faults.
  always_ff @(posedge clk) begin
    if (rst) begin
      pump_en_o  <= 1'b0;
      aux_gate_o <= 1'b0;
    end else begin
      pump_en_o  <= syn_in[0];
      aux_gate_o <= ~syn_in[3];
    end
  end

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int DEAD_CYCLES = 16,
  parameter int FILT_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic aux_req_n_i,
  input logic uv_logic_i,
  input logic uv_motor_i,
  input logic hs_a_o,
  input logic ls_a_o,
  input logic hs_b_o,
  input logic ls_b_o,
  input logic aux_gate_o,
  input logic pump_en_o
);

  localparam int LAT = SYNC_STAGES + 1;

  logic [31:0] since_rst, off_a, off_b, hold_ul, hold_um;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      off_a     <= '0;
      off_b     <= '0;
      hold_ul   <= '0;
      hold_um   <= '0;
    end else begin
      if (since_rst != '1) since_rst <= since_rst + 32'd1;
      off_a   <= (!hs_a_o && !ls_a_o) ? ((off_a != '1) ? off_a + 32'd1 : off_a) : '0;
      off_b   <= (!hs_b_o && !ls_b_o) ? ((off_b != '1) ? off_b + 32'd1 : off_b) : '0;
      hold_ul <= uv_logic_i ? ((hold_ul != '1) ? hold_ul + 32'd1 : hold_ul) : '0;
      hold_um <= uv_motor_i ? ((hold_um != '1) ? hold_um + 32'd1 : hold_um) : '0;
    end
  end

  assert_no_overlap_a_R9: assert property (@(posedge clk) disable iff (rst)
    !(hs_a_o && ls_a_o));
  assert_no_overlap_b_R9: assert property (@(posedge clk) disable iff (rst)
    !(hs_b_o && ls_b_o));

  assert_dead_hs_a_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_a_o) |-> off_a >= 32'(DEAD_CYCLES));
  assert_dead_ls_a_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_a_o) |-> off_a >= 32'(DEAD_CYCLES));
  assert_dead_hs_b_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_b_o) |-> off_b >= 32'(DEAD_CYCLES));
  assert_dead_ls_b_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_b_o) |-> off_b >= 32'(DEAD_CYCLES));

  assert_fault_release_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_ul >= 32'(FILT_CYCLES + 3) || hold_um >= 32'(FILT_CYCLES + 3))
      |-> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

  assert_pump_follows_en_R5: assert property (@(posedge clk) disable iff (rst)
    since_rst >= 32'(LAT) |-> pump_en_o == $past(en_i, LAT));

  assert_aux_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
    since_rst >= 32'(LAT) |-> aux_gate_o == !$past(aux_req_n_i, LAT));

endmodule

bind hbridge_gate_ctrl hbg_checker #(
  .DEAD_CYCLES (DEAD_CYCLES),
  .FILT_CYCLES (FILT_CYCLES),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .aux_req_n_i (aux_req_n_i),
  .uv_logic_i  (uv_logic_i),
  .uv_motor_i  (uv_motor_i),
  .hs_a_o      (hs_a_o),
  .ls_a_o      (ls_a_o),
  .hs_b_o      (hs_b_o),
  .ls_b_o      (ls_b_o),
  .aux_gate_o  (aux_gate_o),
  .pump_en_o   (pump_en_o)
);

// File: tb/sim_hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hbridge_gate_ctrl;

  localparam int DEAD = 4;
  localparam int FILT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en, da, db, rq_n, uvl, uvm;
  logic hs_a, ls_a, hs_b, ls_b, aux, pump;

  int checks = 0;
  int fails  = 0;
  bit overlap_seen = 1'b0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;  // 125 MHz

  hbridge_gate_ctrl #(
    .DEAD_CYCLES (DEAD),
    .FILT_CYCLES (FILT),
    .SYNC_STAGES (2)
  ) u0 (
    .clk (clk), .rst (rst), .en_i (en), .dir_a_i (da), .dir_b_i (db),
    .aux_req_n_i (rq_n), .uv_logic_i (uvl), .uv_motor_i (uvm),
    .hs_a_o (hs_a), .ls_a_o (ls_a), .hs_b_o (hs_b), .ls_b_o (ls_b),
    .aux_gate_o (aux), .pump_en_o (pump)
  );

  // Output vector: {hs_a, ls_a, hs_b, ls_b, aux, pump}
  function automatic logic [5:0] mk(logic h_a, logic l_a, logic h_b, logic l_b,
                                    logic ax, logic pm);
    return {h_a, l_a, h_b, l_b, ax, pm};
  endfunction

  task automatic drive(logic e, logic a, logic b, logic r, logic ul, logic um);
    en = e; da = a; db = b; rq_n = r; uvl = ul; uvm = um;
  endtask

  // Driver side of the scoreboard: wait n negedges, then queue an expectation
  task automatic chk(int n, logic [5:0] e, string tag);
    repeat (n) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && ((hs_a && ls_a) || (hs_b && ls_b))) overlap_seen = 1'b1;
      while (exp_q.size() > 0) begin
        logic [5:0] e;
        string      t;
        logic [5:0] obs;
        e   = exp_q.pop_front();
        t   = tag_q.pop_front();
        obs = {hs_a, ls_a, hs_b, ls_b, aux, pump};
        checks++;
        if (obs !== e) begin
          fails++;
          $display("FAIL %s: got %b expected %b", t, obs, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    drive(0, 0, 0, 1, 0, 0);
    chk(3, mk(0,0,0,0,0,0), "R10 outputs low in reset");
    rst = 1'b0;
    chk(12, mk(0,1,0,1,0,0), "R4 brake after reset, pump asleep");

    // Leave brake into forward: leg A passes a dead window
    drive(1, 1, 0, 1, 0, 0);
    chk(2, mk(0,1,0,1,0,0), "R10 no change before third edge");
    chk(1, mk(0,0,0,1,0,1), "R9 leg A off, R5 pump on");
    chk(DEAD - 1, mk(0,0,0,1,0,1), "R9 leg A still off at end of dead window");
    chk(1, mk(1,0,0,1,0,1), "R1 forward polarity");

    // Reverse: both legs swap through a dead window
    drive(1, 0, 1, 1, 0, 0);
    chk(2, mk(1,0,0,1,0,1), "R10 forward held two edges");
    chk(1, mk(0,0,0,0,0,1), "R9 both legs off on reversal");
    chk(DEAD - 1, mk(0,0,0,0,0,1), "R9 legs off through dead window");
    chk(1, mk(0,1,1,0,0,1), "R1 reverse polarity");

    drive(1, 1, 1, 1, 0, 0);
    chk(20, mk(0,1,0,1,0,1), "R2 dynamic brake with both dirs high");

    drive(1, 0, 0, 1, 0, 0);
    chk(20, mk(0,0,0,0,0,1), "R3 release with both dirs low");

    drive(0, 1, 0, 1, 0, 0);
    chk(20, mk(0,1,0,1,0,0), "R4 enable low brakes, R5 pump off");
    drive(0, 0, 0, 1, 0, 0);
    chk(20, mk(0,1,0,1,0,0), "R4 enable low brakes despite release pattern");

    drive(0, 0, 0, 0, 0, 0);
    chk(2, mk(0,1,0,1,0,0), "R8 aux before latency");
    chk(1, mk(0,1,0,1,1,0), "R8 aux active on low request");

    drive(1, 1, 0, 0, 0, 0);
    chk(20, mk(1,0,0,1,1,1), "R1 forward again with aux");

    // Sustained logic-supply fault
    drive(1, 1, 0, 0, 1, 0);
    chk(FILT + 2, mk(1,0,0,1,1,1), "R6 still driving before filter expires");
    chk(1, mk(0,0,0,0,1,1), "R6 bridge released, R8 aux unaffected");
    drive(1, 1, 0, 0, 0, 0);
    chk(FILT + 2, mk(0,0,0,0,1,1), "R7 still released while clear filters");
    chk(1, mk(1,0,0,1,1,1), "R7 resumed forward");

    // Motor-supply pulse one clock shorter than the filter
    drive(1, 1, 0, 0, 0, 1);
    repeat (FILT - 1) @(negedge clk);
    drive(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < FILT + 6; i++) chk(1, mk(1,0,0,1,1,1), "R6 short pulse ignored");

    // Sustained motor-supply fault, pins change during fault
    drive(1, 1, 0, 1, 0, 1);
    chk(20, mk(0,0,0,0,0,1), "R6 motor fault releases bridge");
    drive(1, 0, 1, 1, 0, 1);
    chk(20, mk(0,0,0,0,0,1), "R6 bridge stays released in fault");
    drive(1, 0, 1, 1, 0, 0);
    chk(25, mk(0,1,1,0,0,1), "R7 resume follows current pins");

    repeat (3) @(negedge clk);
    checks++;
    if (overlap_seen) begin
      fails++;
      $display("FAIL R9: got overlapping switches expected none");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule